// File: doc/BRIEF.md
# Two-Pass Preamble Gain Controller

This block sets the gain of a receiver's analog gain stage at the start of each received frame. Once the upstream power detector flags a signal, it averages the instantaneous power I²+Q² of the signed baseband samples over one preamble symbol. It converts that average to decibels and moves the gain by the full error against a programmable target. It then writes the new gain word to the analog front end over a small SPI master.

After the write, the block measures the following preamble symbol in the same way and applies a second, bounded trim. This trim is also written over SPI. The gain word is kept inside the stage's 0 to 73 dB range, in 1 dB steps.

A second path runs alongside the gain loop. From detection until the frame-delimiter strobe, it accumulates sample power for a link-quality figure. When the strobe arrives, it latches the mean power per counted sample.

Top module: `agc_two_pass`

## Requirements
- R1: While reset is high, and on the first cycle after it, `gain_word` equals GAIN_INIT (40). At the same time `spi_csn` is 1, `spi_sclk` is 0, and `lqi_val`, `lqi_valid` and `agc_done` are 0.
- R2: A `sig_det` pulse seen while the controller is idle starts a cycle. The coarse window is then formed from the next 64 samples that have `smp_valid` high. A `sig_det` pulse during a cycle that is already running has no effect on its windows.
- R3: The level of a window is computed from its average A = floor(sum of I²+Q² / 64). If k is the index of the highest set bit of A, and f is the two bits of A just below bit k (zero-filled below bit 0), the level is dB = 3·k + L[f] with L = {0,1,2,2}. The level is 0 when A is 0.
- R4: After the coarse window, the new gain is clamp(gain + tgt_db − dB, 0, 73).
- R5: After the coarse write, a fine window of 64 samples is taken. The gain then moves by tgt_db − dB, limited to the range −3 to +3, and the result is clamped to 0..73.
- R6: Each gain write is one SPI frame of 16 bits, sent MSB first. The first 8 bits are the register address 0x1A, and the last 8 bits are {1'b0, gain[6:0]}. `spi_csn` is low for the whole frame. `spi_mosi` changes only while `spi_sclk` is low, and the receiver samples it on the rising edge. `spi_sclk` idles low.
- R7: Samples that arrive while an SPI write is in progress are left out of both the gain windows and the link-quality average.
- R8: `gain_word` never exceeds 73. It changes only on the cycle in which a write frame begins, and it then holds the value being written.
- R9: From the first `sig_det` after reset, or after the previous delimiter, every counted sample adds to the link-quality sum. An `sfd_hit` then sets `lqi_val` to floor(sum/count) and pulses `lqi_valid` for one cycle.
- R10: `agc_done` pulses for one cycle after the fine write has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_i | input | 8 | Signed in-phase sample |
| smp_q | input | 8 | Signed quadrature sample |
| sig_det | input | 1 | Signal-detected pulse from the power detector |
| sfd_hit | input | 1 | Frame-delimiter-found pulse |
| tgt_db | input | 7 | Target level in dB, same scale as R3 |
| gain_word | output | 7 | Gain currently commanded, in dB |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| lqi_val | output | 16 | Latched mean power for link quality |
| lqi_valid | output | 1 | One-cycle pulse when `lqi_val` updates |
| agc_done | output | 1 | One-cycle pulse at the end of the fine write |

## Verification
The bench targets four risks: a second detection arriving mid-window, full-scale junk samples arriving while a frame is still being shifted out, fine trims that must saturate at ±3, and gains that must clip at both 0 and 73.

A window counter that restarts on the repeated detection, or that counts junk samples, would yield a different dB level. That would show up as a different gain in the written frame and a shifted link-quality mean. An unclamped trim would show up as a jump larger than 3, and missing range limits would show up as a gain outside 0..73. A reversed bit order or the wrong address would show up in the captured frame.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MEAS_C,
        S_WR_C,
        S_MEAS_F,
        S_WR_F
    } agc_state_t;

    // Piecewise log estimate: 3 dB per octave plus two mantissa bits
    function automatic logic [6:0] pow_to_db(input logic [31:0] avg);
        logic [4:0]  msb;
        logic        hit;
        logic [33:0] shf;
        logic [1:0]  frac_add;
        msb = '0;
        hit = 1'b0;
        for (int b = 0; b < 32; b++) begin
            if (avg[b]) begin
                msb = 5'(b);
                hit = 1'b1;
            end
        end
        shf = {avg, 2'b00} >> msb;
        case (shf[1:0])
            2'd0:    frac_add = 2'd0;
            2'd1:    frac_add = 2'd1;
            default: frac_add = 2'd2;
        endcase
        if (!hit) return 7'd0;
        return 7'(3 * msb) + 7'(frac_add);
    endfunction

endpackage

// File: rtl/agc_spi_tx.sv
module agc_spi_tx #(
    parameter int FRAME_W = 16,
    parameter int HALF    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               done,
    output logic               sclk,
    output logic               mosi
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [CW-1:0]      tick;
    logic [BW-1:0]      bitn;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            sclk  <= 1'b0;
            shreg <= '0;
            tick  <= '0;
            bitn  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    shreg <= frame;
                    tick  <= '0;
                    bitn  <= '0;
                    sclk  <= 1'b0;
                end
            end else if (tick == CW'(HALF - 1)) begin
                tick <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bitn == BW'(FRAME_W - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitn  <= bitn + 1'b1;
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                    end
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign mosi = shreg[FRAME_W-1];
endmodule

// File: rtl/agc_pwr_win.sv
module agc_pwr_win #(
    parameter int PW      = 16,
    parameter int WIN_LEN = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [PW-1:0] pow,
    output logic          done,
    output logic [PW-1:0] avg
);
    localparam int LW = $clog2(WIN_LEN);
    localparam int AW = PW + LW;

    logic [AW-1:0] acc, acc_nx;
    logic [LW-1:0] cnt;

    assign acc_nx = acc + AW'(pow);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            cnt  <= '0;
            done <= 1'b0;
            avg  <= '0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                acc <= '0;
                cnt <= '0;
            end else if (en) begin
                if (cnt == LW'(WIN_LEN - 1)) begin
                    done <= 1'b1;
                    avg  <= acc_nx[LW +: PW];
                    acc  <= '0;
                    cnt  <= '0;
                end else begin
                    acc <= acc_nx;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/agc_lqi.sv
module agc_lqi #(
    parameter int PW    = 16,
    parameter int ACC_W = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          det,
    input  logic          sfd,
    input  logic          en,
    input  logic [PW-1:0] pow,
    output logic [PW-1:0] lqi_val,
    output logic          lqi_valid
);
    logic             run;
    logic [ACC_W-1:0] sum;
    logic [CNT_W-1:0] cnt;
    logic [ACC_W-1:0] quot;

    assign quot = (cnt == '0) ? '0 : sum / ACC_W'(cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            sum       <= '0;
            cnt       <= '0;
            lqi_val   <= '0;
            lqi_valid <= 1'b0;
        end else begin
            lqi_valid <= 1'b0;
            if (!run) begin
                if (det) begin
                    run <= 1'b1;
                    sum <= '0;
                    cnt <= '0;
                end
            end else if (sfd) begin
                run       <= 1'b0;
                lqi_valid <= 1'b1;
                lqi_val   <= PW'(quot);
            end else if (en) begin
                sum <= sum + ACC_W'(pow);
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/agc_two_pass.sv
module agc_two_pass
    import agc_pkg::*;
#(
    parameter int          SAMP_W    = 8,
    parameter int          GAIN_W    = 7,
    parameter int          GAIN_MAX  = 73,
    parameter int          GAIN_INIT = 40,
    parameter int          FINE_LIM  = 3,
    parameter int          WIN_LEN   = 64,
    parameter int          SPI_HALF  = 2,
    parameter logic [7:0]  GAIN_ADDR = 8'h1A
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [SAMP_W-1:0] smp_i,
    input  logic signed [SAMP_W-1:0] smp_q,
    input  logic                     sig_det,
    input  logic                     sfd_hit,
    input  logic [GAIN_W-1:0]        tgt_db,
    output logic [GAIN_W-1:0]        gain_word,
    output logic                     spi_csn,
    output logic                     spi_sclk,
    output logic                     spi_mosi,
    output logic [2*SAMP_W-1:0]      lqi_val,
    output logic                     lqi_valid,
    output logic                     agc_done
);
    localparam int PW      = 2 * SAMP_W;
    localparam int EW      = GAIN_W + 3;
    localparam int FRAME_W = 16;

    agc_state_t st;

    logic signed [PW-1:0] isq, qsq;
    logic [PW-1:0]        smp_pow;
    logic                 meas_st, win_en, win_clr, win_done;
    logic [PW-1:0]        win_avg;
    logic [6:0]           meas_db;
    logic signed [EW-1:0] err, step, gsum;
    logic [GAIN_W-1:0]    gain_nx;
    logic                 spi_start, spi_busy, spi_done;
    logic [FRAME_W-1:0]   frame;

    assign isq     = PW'(smp_i) * PW'(smp_i);
    assign qsq     = PW'(smp_q) * PW'(smp_q);
    assign smp_pow = $unsigned(isq) + $unsigned(qsq);

    assign meas_st = (st == S_MEAS_C) || (st == S_MEAS_F);
    assign win_en  = smp_valid && meas_st;
    assign win_clr = ((st == S_IDLE) && sig_det) || ((st == S_WR_C) && spi_done);

    agc_pwr_win #(.PW(PW), .WIN_LEN(WIN_LEN)) u_win (
        .clk  (clk),
        .rst  (rst),
        .clr  (win_clr),
        .en   (win_en),
        .pow  (smp_pow),
        .done (win_done),
        .avg  (win_avg)
    );

    assign meas_db = pow_to_db(32'(win_avg));

    always_comb begin
        err = $signed(EW'(tgt_db)) - $signed(EW'(meas_db));
        step = err;
        if (st == S_MEAS_F) begin
            if (err > $signed(EW'(FINE_LIM)))
                step = $signed(EW'(FINE_LIM));
            else if (err < -$signed(EW'(FINE_LIM)))
                step = -$signed(EW'(FINE_LIM));
        end
        gsum = $signed(EW'(gain_word)) + step;
        if (gsum < 0)
            gain_nx = '0;
        else if (gsum > $signed(EW'(GAIN_MAX)))
            gain_nx = GAIN_W'(GAIN_MAX);
        else
            gain_nx = GAIN_W'(gsum);
    end

    assign spi_start = win_done && meas_st;
    assign frame     = {GAIN_ADDR, 8'(gain_nx)};

    agc_spi_tx #(.FRAME_W(FRAME_W), .HALF(SPI_HALF)) u_spi (
        .clk   (clk),
        .rst   (rst),
        .start (spi_start),
        .frame (frame),
        .busy  (spi_busy),
        .done  (spi_done),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi)
    );

    assign spi_csn = !spi_busy;

    agc_lqi #(.PW(PW)) u_lqi (
        .clk       (clk),
        .rst       (rst),
        .det       (sig_det),
        .sfd       (sfd_hit),
        .en        (smp_valid && !spi_busy && !spi_start),
        .pow       (smp_pow),
        .lqi_val   (lqi_val),
        .lqi_valid (lqi_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            gain_word <= GAIN_W'(GAIN_INIT);
            agc_done  <= 1'b0;
        end else begin
            agc_done <= 1'b0;
            case (st)
                S_IDLE:   if (sig_det) st <= S_MEAS_C;
                S_MEAS_C: if (win_done) begin
                    gain_word <= gain_nx;
                    st        <= S_WR_C;
                end
                S_WR_C:   if (spi_done) st <= S_MEAS_F;
                S_MEAS_F: if (win_done) begin
                    gain_word <= gain_nx;
                    st        <= S_WR_F;
                end
                S_WR_F:   if (spi_done) begin
                    agc_done <= 1'b1;
                    st       <= S_IDLE;
                end
                default:  st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/agc_two_pass_chk.sv
module agc_two_pass_chk #(
    parameter int GAIN_W   = 7,
    parameter int GAIN_MAX = 73
) (
    input logic              clk,
    input logic              rst,
    input logic [GAIN_W-1:0] gain_word,
    input logic              spi_csn,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic              lqi_valid,
    input logic              agc_done
);
    // R8
    gain_range_chk: assert property (@(posedge clk) disable iff (rst)
        gain_word <= GAIN_W'(GAIN_MAX));

    // R8
    gain_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(gain_word) |-> $fell(spi_csn));

    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> !spi_sclk);

    // R6
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R9
    lqi_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        lqi_valid |=> !lqi_valid);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        agc_done |-> (spi_csn && !$past(agc_done)));
endmodule

bind agc_two_pass agc_two_pass_chk #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gain_word (gain_word),
    .spi_csn   (spi_csn),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .lqi_valid (lqi_valid),
    .agc_done  (agc_done)
);

// File: tb/agc_two_pass_bench.sv
module agc_two_pass_bench;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_valid = 1'b0;
    logic signed [7:0] smp_i = '0;
    logic signed [7:0] smp_q = '0;
    logic              sig_det = 1'b0;
    logic              sfd_hit = 1'b0;
    logic [6:0]        tgt_db = 7'd30;
    logic [6:0]        gain_word;
    logic              spi_csn, spi_sclk, spi_mosi;
    logic [15:0]       lqi_val;
    logic              lqi_valid, agc_done;

    int total = 0;
    int bad = 0;
    int exp_gain = 40;
    int nbits = 0;
    int frames = 0;
    int done_cnt = 0;
    int lqiv_cnt = 0;
    logic [15:0] shreg = '0;
    logic [15:0] last_frame = '0;
    bit finished = 0;

    always #2 clk = ~clk;

    agc_two_pass u_agc_two_pass (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .sig_det(sig_det), .sfd_hit(sfd_hit), .tgt_db(tgt_db), .gain_word(gain_word),
        .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .lqi_val(lqi_val), .lqi_valid(lqi_valid), .agc_done(agc_done)
    );

    always @(negedge spi_csn) nbits = 0;
    always @(posedge spi_sclk) begin
        shreg = {shreg[14:0], spi_mosi};
        nbits++;
    end
    always @(posedge spi_csn) if (nbits == 16) begin
        last_frame = shreg;
        frames++;
        nbits = 0;
    end
    always @(posedge clk) begin
        if (!rst && agc_done) done_cnt++;
        if (!rst && lqi_valid) lqiv_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int db_of(input int avg);
        int k = -1;
        int f;
        for (int b = 0; b < 31; b++) if ((avg >> b) & 1) k = b;
        if (k < 0) return 0;
        f = ((avg << 2) >> k) & 3;
        return 3 * k + ((f == 0) ? 0 : (f == 1) ? 1 : 2);
    endfunction

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : (v > hi) ? hi : v;
    endfunction

    task automatic send(input int n, input int iv, input int qv, input int det_at);
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_i = 8'(iv);
            smp_q = 8'(qv);
            sig_det = (s == det_at);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        sig_det = 1'b0;
    endtask

    // one full coarse + fine pass; checks frames and gain after each write
    task automatic run_pass(input string tag, input int ci, input int cq,
                            input int fi, input int fq, input bit junk, input bit redet);
        int f0, d0, step;
        f0 = frames;
        d0 = done_cnt;
        @(negedge clk); sig_det = 1'b1;
        @(negedge clk); sig_det = 1'b0;
        send(64, ci, cq, redet ? 10 : -1);
        exp_gain = clampi(exp_gain + int'(tgt_db) - db_of(ci*ci + cq*cq), 0, 73);
        wait (spi_csn == 1'b0);
        if (junk) send(20, -128, -128, 5);
        wait (spi_csn == 1'b1);
        repeat (2) @(negedge clk);
        // R4 R6 coarse write frame
        chk(frames == f0 + 1, {tag, " R6 coarse frame count"}, frames, f0 + 1);
        chk(last_frame == {8'h1A, 1'b0, 7'(exp_gain)}, {tag, " R4 coarse frame"},
            last_frame, {8'h1A, 1'b0, 7'(exp_gain)});
        chk(gain_word == 7'(exp_gain), {tag, " R8 coarse gain_word"}, gain_word, exp_gain);
        send(64, fi, fq, -1);
        step = clampi(int'(tgt_db) - db_of(fi*fi + fq*fq), -3, 3);
        exp_gain = clampi(exp_gain + step, 0, 73);
        wait (spi_csn == 1'b0);
        wait (spi_csn == 1'b1);
        repeat (3) @(negedge clk);
        // R5 fine trim
        chk(last_frame == {8'h1A, 1'b0, 7'(exp_gain)}, {tag, " R5 fine frame"},
            last_frame, {8'h1A, 1'b0, 7'(exp_gain)});
        chk(gain_word == 7'(exp_gain), {tag, " R5 fine gain_word"}, gain_word, exp_gain);
        // R10
        chk(done_cnt == d0 + 1, {tag, " R10 done pulse"}, done_cnt, d0 + 1);
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        // R1
        chk(gain_word == 7'd40, "R1 gain reset", gain_word, 40);
        chk(spi_csn && !spi_sclk, "R1 spi idle", {spi_csn, spi_sclk}, 2);
        chk(lqi_val == 0 && !lqi_valid && !agc_done, "R1 outputs zero", lqi_val, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(gain_word == 7'd40, "R1 gain after reset", gain_word, 40);
    endtask

    // R2 R3 R7 R9: redetect mid-window, junk during write, link quality mean
    task automatic t_basic;
        int l0;
        tgt_db = 7'd30;
        run_pass("basic", 50, 50, 20, 20, 1'b1, 1'b1);
        l0 = lqiv_cnt;
        @(negedge clk); sfd_hit = 1'b1;
        @(negedge clk); sfd_hit = 1'b0;
        repeat (2) @(negedge clk);
        chk(lqiv_cnt == l0 + 1, "R9 lqi_valid pulse", lqiv_cnt, l0 + 1);
        chk(lqi_val == 16'((64*5000 + 64*800) / 128), "R7 R9 lqi mean", lqi_val,
            (64*5000 + 64*800) / 128);
    endtask

    task automatic t_clamp_high;
        tgt_db = 7'd70;
        run_pass("high R4 R5", 0, 0, 0, 0, 1'b0, 1'b0);
        chk(gain_word == 7'd73, "R8 ceiling", gain_word, 73);
    endtask

    task automatic t_fine_neg;
        tgt_db = 7'd0;
        run_pass("fine_neg R3 R5", 100, 100, 10, 10, 1'b0, 1'b0);
    endtask

    task automatic t_clamp_low;
        tgt_db = 7'd0;
        run_pass("low R4", 127, 127, 0, 0, 1'b0, 1'b0);
        chk(gain_word == 7'd0, "R4 floor", gain_word, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_clamp_high();
        t_fine_neg();
        t_clamp_low();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule